// File: doc/BRIEF.md
# Self-Advancing Multi-Channel Compare Scheduler

This block holds one free-running timestamp counter shared by several compare channels. Each channel raises a one-cycle event when the counter reaches its compare value, and then pushes that compare value forward by its own period. Software therefore programs a channel once and gets a repeating event with no further intervention. Because every channel is scheduled from the same counter, unrelated rates stay phase-coherent. One example is a once-per-second marker alongside a sampling strobe whose period is not a whole number of ticks.

A period has two parts. The integer part is a whole number of ticks. The fractional part is a 16-bit binary fraction that a per-channel accumulator sums, and each carry out of the accumulator lengthens that step by one tick. Over many steps the event times track the exact non-integer period without drift. A channel's start value may be written only while the channel is disabled, and the write also clears its fractional accumulator. Each channel drives a one-cycle pulse, suitable for a pin, and a sticky interrupt flag that is cleared by writing one.

Top module: `tcmp_sched`

## Requirements
- R1: After reset the counter output is 0; it then rises by exactly one every clock cycle and wraps to 0 after its maximum value.
- R2: An enabled channel matches when the difference counter minus compare, taken as a CW-bit two's-complement number, is zero or positive. Its event output is high for the single cycle that follows each match cycle.
- R3: Each match adds the integer period plus the carry of the fractional accumulator to the compare value, where the accumulator is FW bits wide and sums the fractional period at every match. After k matches from a start value S, the compare value is S + k*int + floor(k*frac/2^FW), modulo 2^CW.
- R4: A compare value that is already behind the counter, by less than half the counter range, matches at once. It does not wait for the counter to wrap.
- R5: A disabled channel produces no events, does not set its interrupt flag, and keeps its compare value unless a start value is written.
- R6: A start write to a disabled channel loads the compare value in the next cycle and clears its fractional accumulator. A start write to an enabled channel is ignored.
- R7: The interrupt flag is set by every match and stays set until a one is written to its clear bit. When a set and a clear land in the same cycle, the flag stays set.
- R8: Channels work independently of one another. Each uses its own period, enable, start value and clear bit, and all of them compare against the one shared counter.
- R9: Reset clears all compare values, event outputs and interrupt flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | CH | Per-channel enable |
| per_int | input | CH*PW | Integer period per channel, channel i at bits [i*PW +: PW] |
| per_frac | input | CH*FW | Fractional period per channel, in units of 2^-FW tick |
| start_we | input | CH | Start-value write strobe per channel |
| start_val | input | CH*CW | Start compare value per channel |
| irq_clr | input | CH | Write-one-to-clear for the interrupt flags |
| cnt_o | output | CW | Shared timestamp counter |
| cmp_o | output | CH*CW | Current compare value per channel |
| evt_o | output | CH | One-cycle event pulse per channel |
| irq_o | output | CH | Sticky interrupt flag per channel |

## Verification
Rounds of random configuration use short integer periods and random fractions, with start values either ahead of the counter or a little behind it. They separate a correct carry from an accumulator that drops or doubles carries, and a signed match from a plain equality match. Directed runs cover a late start, a write attempted while a channel is enabled, a channel that fires every cycle while its flag is being cleared, and a long run with a near-4800-rate fraction across a counter wrap. Together these expose wrong write gating, a clear that beats the set, and a compare that misbehaves at the wrap.

// File: rtl/tcmp_sched.sv
module tcmp_sched #(
  parameter int CH = 3,
  parameter int CW = 32,
  parameter int PW = 32,
  parameter int FW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH-1:0]    ch_en,
  input  logic [CH*PW-1:0] per_int,
  input  logic [CH*FW-1:0] per_frac,
  input  logic [CH-1:0]    start_we,
  input  logic [CH*CW-1:0] start_val,
  input  logic [CH-1:0]    irq_clr,
  output logic [CW-1:0]    cnt_o,
  output logic [CH*CW-1:0] cmp_o,
  output logic [CH-1:0]    evt_o,
  output logic [CH-1:0]    irq_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [CW-1:0] cmp_q;
    logic [FW-1:0] acc_q;
    logic          evt_q;
    logic          irq_q;
    logic [CW-1:0] diff;
    logic          hit;
    logic [FW:0]   fsum;
    logic [CW-1:0] step;

    assign diff = cnt_q - cmp_q;
    assign hit  = ch_en[g] & ~diff[CW-1];
    assign fsum = {1'b0, acc_q} + {1'b0, per_frac[g*FW +: FW]};
    assign step = CW'(per_int[g*PW +: PW]) + CW'(fsum[FW]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q <= '0;
        acc_q <= '0;
      end else if (hit) begin
        cmp_q <= cmp_q + step;
        acc_q <= fsum[FW-1:0];
      end else if (!ch_en[g] && start_we[g]) begin
        cmp_q <= start_val[g*CW +: CW];
        acc_q <= '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        evt_q <= 1'b0;
        irq_q <= 1'b0;
      end else begin
        evt_q <= hit;
        irq_q <= (irq_q & ~irq_clr[g]) | hit;
      end
    end

    assign cmp_o[g*CW +: CW] = cmp_q;
    assign evt_o[g] = evt_q;
    assign irq_o[g] = irq_q;
  end

endmodule

// File: rtl/tcmp_sched_chk.sv
module tcmp_sched_chk #(
  parameter int CH = 3,
  parameter int CW = 32,
  parameter int PW = 32,
  parameter int FW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CH-1:0]    ch_en,
  input logic [CH*PW-1:0] per_int,
  input logic [CH-1:0]    start_we,
  input logic [CH-1:0]    irq_clr,
  input logic [CW-1:0]    cnt_o,
  input logic [CH*CW-1:0] cmp_o,
  input logic [CH-1:0]    evt_o,
  input logic [CH-1:0]    irq_o
);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_o == CW'($past(cnt_o) + 1'b1));

  for (genvar i = 0; i < CH; i++) begin : g_a
    assert_evt_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[i] |-> irq_o[i]);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[i] && !irq_clr[i]) |=> irq_o[i]);

    assert_dis_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> !evt_o[i]);

    assert_dis_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[i] && !start_we[i]) |=> $stable(cmp_o[i*CW +: CW]));

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[i] |->
        ((CW'(cmp_o[i*CW +: CW] - $past(cmp_o[i*CW +: CW])) == CW'($past(per_int[i*PW +: PW]))) ||
         (CW'(cmp_o[i*CW +: CW] - $past(cmp_o[i*CW +: CW])) == CW'($past(per_int[i*PW +: PW]) + 1'b1))));
  end

endmodule

bind tcmp_sched tcmp_sched_chk #(.CH(CH), .CW(CW), .PW(PW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .per_int(per_int),
  .start_we(start_we), .irq_clr(irq_clr), .cnt_o(cnt_o),
  .cmp_o(cmp_o), .evt_o(evt_o), .irq_o(irq_o)
);

// File: tb/tcmp_sched_tb_top.sv
module tcmp_sched_tb_top;
  localparam int CH = 3;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int FW = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CH-1:0]    ch_en = '0;
  logic [CH*PW-1:0] per_int = '0;
  logic [CH*FW-1:0] per_frac = '0;
  logic [CH-1:0]    start_we = '0;
  logic [CH*CW-1:0] start_val = '0;
  logic [CH-1:0]    irq_clr = '0;
  logic [CW-1:0]    cnt_o;
  logic [CH*CW-1:0] cmp_o;
  logic [CH-1:0]    evt_o;
  logic [CH-1:0]    irq_o;

  always #4 clk = ~clk;

  tcmp_sched #(.CH(CH), .CW(CW), .PW(PW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .per_int(per_int),
    .per_frac(per_frac), .start_we(start_we), .start_val(start_val),
    .irq_clr(irq_clr), .cnt_o(cnt_o), .cmp_o(cmp_o), .evt_o(evt_o), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit rnd_clr = 0;

  logic [CW-1:0] m_cnt;
  logic [CW-1:0] m_cmp [CH];
  logic [CW-1:0] m_start [CH];
  longint        m_k [CH];
  logic [CH-1:0] m_evt, m_irq;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] sched(logic [CW-1:0] s, longint k, longint pi, longint pf);
    longint t;
    t = longint'(s) + k * pi + ((k * pf) >> FW);
    return CW'(t);
  endfunction

  task automatic model_step();
    logic [CW-1:0] d;
    logic hit;
    for (int i = 0; i < CH; i++) begin
      d = m_cnt - m_cmp[i];
      hit = ch_en[i] && !d[CW-1];
      m_irq[i] = (m_irq[i] & ~irq_clr[i]) | hit;
      m_evt[i] = hit;
      if (hit) begin
        m_k[i]++;
        m_cmp[i] = sched(m_start[i], m_k[i], longint'(per_int[i*PW +: PW]), longint'(per_frac[i*FW +: FW]));
      end else if (!ch_en[i] && start_we[i]) begin
        m_start[i] = start_val[i*CW +: CW];
        m_k[i] = 0;
        m_cmp[i] = start_val[i*CW +: CW];
      end
    end
    m_cnt = m_cnt + 1'b1;
  endtask

  task automatic compare_all();
    chk("R1 counter", longint'(cnt_o), longint'(m_cnt));
    for (int i = 0; i < CH; i++) begin
      chk($sformatf("R3 R8 compare ch%0d", i), longint'(cmp_o[i*CW +: CW]), longint'(m_cmp[i]));
      if (ch_en[i]) chk($sformatf("R2 event ch%0d", i), longint'(evt_o[i]), longint'(m_evt[i]));
      else          chk($sformatf("R5 disabled event ch%0d", i), longint'(evt_o[i]), longint'(m_evt[i]));
      chk($sformatf("R7 irq ch%0d", i), longint'(irq_o[i]), longint'(m_irq[i]));
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    if (rnd_clr) irq_clr = CH'($urandom);
    else         irq_clr = '0;
    compare_all();
  endtask

  task automatic run(int n);
    for (int j = 0; j < n; j++) tick();
  endtask

  task automatic set_per(int i, int pi, int pf);
    per_int[i*PW +: PW] = PW'(pi);
    per_frac[i*FW +: FW] = FW'(pf);
  endtask

  task automatic load(int i, logic [CW-1:0] v);
    start_val[i*CW +: CW] = v;
    start_we[i] = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_0c11));
    m_cnt = '0;
    m_evt = '0;
    m_irq = '0;
    for (int i = 0; i < CH; i++) begin
      m_cmp[i] = '0; m_start[i] = '0; m_k[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset counter", longint'(cnt_o), 0);
    chk("R9 reset compare", longint'(cmp_o), 0);
    chk("R9 reset event", longint'(evt_o), 0);
    chk("R9 reset irq", longint'(irq_o), 0);

    set_per(0, 7, 0);
    set_per(1, 5, 32768);
    set_per(2, 3, 21845);
    load(0, 16'd40); load(1, 16'd10); load(2, 16'd25);
    tick();
    start_we = '0;
    chk("R6 load while disabled", longint'(cmp_o[0 +: CW]), 40);
    ch_en = '1;
    rnd_clr = 1;
    run(200);

    load(0, 16'd999);
    tick();
    start_we = '0;
    chk("R6 write ignored while enabled", longint'(cmp_o[0 +: CW]), longint'(m_cmp[0]));
    run(20);

    rnd_clr = 0;
    irq_clr = 3'b010;
    ch_en[1] = 1'b0;
    tick();
    irq_clr = '0;
    run(100);
    chk("R5 disabled irq stays clear", longint'(irq_o[1]), 0);

    ch_en[0] = 1'b0;
    tick();
    load(0, m_cnt - 16'd50);
    tick();
    start_we = '0;
    ch_en[0] = 1'b1;
    tick();
    chk("R4 late start fires at once", longint'(evt_o[0]), 1);
    run(50);

    ch_en[2] = 1'b0;
    tick();
    set_per(2, 1, 0);
    load(2, m_cnt + 16'd2);
    tick();
    start_we = '0;
    ch_en[2] = 1'b1;
    run(5);
    irq_clr[2] = 1'b1;
    tick(); tick(); tick();
    chk("R7 set wins over clear", longint'(irq_o[2]), 1);
    irq_clr = '0;

    rnd_clr = 1;
    for (int r = 0; r < 20; r++) begin
      ch_en = '0;
      tick();
      for (int i = 0; i < CH; i++) begin
        set_per(i, 1 + ($urandom % 60), $urandom);
        if ($urandom % 3 == 0) load(i, m_cnt - CW'($urandom % 30));
        else                   load(i, m_cnt + CW'($urandom % 100));
      end
      tick();
      start_we = '0;
      ch_en = CH'($urandom) | 3'b001;
      run(300);
    end

    ch_en = '0;
    tick();
    set_per(0, 5208, 21845);
    set_per(1, 30000, 0);
    set_per(2, 11, 40000);
    load(0, m_cnt + 16'd100);
    load(1, m_cnt + 16'd300);
    load(2, m_cnt + 16'd7);
    tick();
    start_we = '0;
    ch_en = '1;
    run(70000);
    chk("R3 fractional compare after wrap", longint'(cmp_o[0 +: CW]), longint'(m_cmp[0]));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule